// File: doc/BRIEF.md
# Count-to-LFSR State Converter

This block takes a plain binary step count and returns the 16-bit state that a shift-register sequence generator reaches after that many steps from its fixed all-ones seed. Software uses the result to load comparators that count with such a generator instead of a binary counter. A comparator of that kind matches on a state, not on a number of steps, so the step count must first be mapped to a state.

A one-cycle `start_i` pulse captures `count_i` and loads the seed. The block then applies one generator step per clock until the count is used up. It then raises `done_o` for one cycle and holds the state on `result_o` until the next conversion completes. While `busy_o` is high, new start pulses are dropped.

Top module: `lfsr_cvt`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `result_o` is 0xFFFF.
- R2: A `start_i` pulse while idle makes `busy_o` 1 from the next cycle and captures `count_i`.
- R3: A count of 0 gives a result of 0xFFFF, with `done_o` rising one cycle after the start edge.
- R4: One step shifts the state left by one bit and places XOR of state bits 15, 4, 2 and 1 into bit 0, keeping 16 bits (counts 1, 2 and 3 give 0xFFFE, 0xFFFC and 0xFFF9).
- R5: The result equals the state after exactly `count` steps from the 0xFFFF seed, for any count up to 65535.
- R6: `done_o` is high for exactly one cycle, and `busy_o` falls on the same edge that `done_o` rises.
- R7: `done_o` rises exactly count+1 clock edges after the edge that accepted the start.
- R8: A `start_i` pulse while busy is ignored: the running count, result and latency are unchanged.
- R9: `result_o` changes only on the edge that raises `done_o`, and is held stable otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| count_i | input | 16 | Number of generator steps to apply |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Generator state after the requested steps |

## Verification
A start accepted at edge k raises `busy_o` from edge k+1 and raises `done_o` with the new `result_o` at edge k+count+1. The bench reference model moves through the same edges, using integer counters and a plain step function. The bench compares all three outputs with the model at every falling edge, after each rising edge has settled and before any input changes. Each transaction also counts the edges from start to done against count+1, and three short counts are checked against hand-derived states.

// File: rtl/lfsr_cvt_pkg.sv
package lfsr_cvt_pkg;
  localparam int unsigned LFSR_W  = 16;
  localparam int unsigned CNT_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  // feedback taps: bits 15, 4, 2, 1
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8016;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cvt_state_e;
endpackage

// File: rtl/lfsr_cvt_step.sv
module lfsr_cvt_step #(
  parameter int unsigned            W    = 16,
  parameter logic [W-1:0]           TAPS = 16'h8016
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] next_o
);
  logic fb;

  always_comb begin
    fb     = ^(state_i & TAPS);
    next_o = {state_i[W-2:0], fb};
  end
endmodule

// File: rtl/lfsr_cvt_ctrl.sv
module lfsr_cvt_ctrl
  import lfsr_cvt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          adv_o,
  output logic          fin_o
);
  cvt_state_e    st_q;
  logic [CW-1:0] rem_q;
  logic          rem_zero;

  assign rem_zero = (rem_q == '0);
  assign busy_o   = (st_q == ST_RUN);
  assign load_o   = (st_q == ST_IDLE) && start_i;
  assign adv_o    = busy_o && !rem_zero;
  assign fin_o    = busy_o && rem_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else if (load_o) begin
      st_q  <= ST_RUN;
      rem_q <= count_i;
    end else if (adv_o) begin
      rem_q <= rem_q - 1'b1;
    end else if (fin_o) begin
      st_q  <= ST_IDLE;
    end
  end

  // R2: accepted start makes the block busy
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R8: start while busy neither reloads nor stops the count
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !rem_zero) |=> (busy_o && rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/lfsr_cvt.sv
module lfsr_cvt
  import lfsr_cvt_pkg::*;
#(
  parameter int unsigned           W    = LFSR_W,
  parameter int unsigned           CW   = CNT_W,
  parameter logic [W-1:0]          SEED = LFSR_SEED,
  parameter logic [W-1:0]          TAPS = LFSR_TAPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  logic         load, adv, fin;
  logic [W-1:0] lfsr_q, lfsr_nx;

  lfsr_cvt_ctrl #(.CW(CW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .count_i (count_i),
    .busy_o  (busy_o),
    .load_o  (load),
    .adv_o   (adv),
    .fin_o   (fin)
  );

  lfsr_cvt_step #(.W(W), .TAPS(TAPS)) u_step (
    .state_i (lfsr_q),
    .next_o  (lfsr_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lfsr_q <= SEED;
    else if (load) lfsr_q <= SEED;
    else if (adv)  lfsr_q <= lfsr_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= SEED;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) result_o <= lfsr_q;
    end
  end

  // R4: each step is a left shift of the previous state
  a_r4_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (lfsr_q[W-1:1] == $past(lfsr_q[W-2:0])));

  // R3: zero count completes on the second edge
  a_r3_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && count_i == '0) |=> ##1 (done_o && result_o == SEED));

  // R6: single-cycle done, busy already low
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9: result held between completions
  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/sim_lfsr_cvt.sv
module sim_lfsr_cvt;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] count = '0;
  logic        busy, done;
  logic [15:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_cvt u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [15:0] ref_steps(input int n);
    logic [15:0] v = 16'hFFFF;
    for (int i = 0; i < n; i++) v = {v[14:0], v[15] ^ v[4] ^ v[2] ^ v[1]};
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy = 0, m_done = 0;
  int          m_rem = 0;
  logic [15:0] m_lv = 16'hFFFF, m_res = 16'hFFFF;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_rem <= 0; m_lv <= 16'hFFFF; m_res <= 16'hFFFF;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin m_busy <= 1; m_rem <= int'(count); m_lv <= 16'hFFFF; end
      end else if (m_rem > 0) begin
        m_rem <= m_rem - 1;
        m_lv  <= {m_lv[14:0], m_lv[15] ^ m_lv[4] ^ m_lv[2] ^ m_lv[1]};
      end else begin
        m_busy <= 0; m_done <= 1; m_res <= m_lv;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(done == m_done, "R6 done", done, m_done);
      chk(result == m_res, "R9 result", result, m_res);
    end
  end

  task automatic run(input int n, input int intrude_at, input int intrude_cnt, output logic [15:0] res);
    int k;
    @(negedge clk);
    count = 16'(n); start = 1;
    @(negedge clk);
    start = 0; count = 16'hA5A5;
    k = 0;
    while (!done && cyc < WATCHDOG) begin
      if (k == intrude_at) begin start = 1; count = 16'(intrude_cnt); end
      @(negedge clk);
      start = 0;
      k++;
    end
    chk(k == n + 1, "R7 latency", k, n + 1);
    chk(result == ref_steps(n), "R5 result", result, ref_steps(n));
    res = result;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(result == 16'hFFFF, "R1 result", result, 16'hFFFF);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    count = 16'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R2 busy after start", busy, 1);
    @(negedge clk);
    chk(done == 1 && busy == 0, "R6 done with busy low", {done, busy}, 2);
    chk(result == 16'hFFFF, "R3 zero count", result, 16'hFFFF);
    @(negedge clk);
    chk(done == 0, "R6 single pulse", done, 0);
    run(0, -1, 0, r);   chk(r == 16'hFFFF, "R3 zero count", r, 16'hFFFF);
    run(1, -1, 0, r);   chk(r == 16'hFFFE, "R4 one step", r, 16'hFFFE);
    run(2, -1, 0, r);   chk(r == 16'hFFFC, "R4 two steps", r, 16'hFFFC);
    run(3, -1, 0, r);   chk(r == 16'hFFF9, "R4 three steps", r, 16'hFFF9);
    run(17, 4, 2, r);   // R8 start while busy
    run(40, 0, 9, r);   // R8 start right after acceptance
    run(300, -1, 0, r);
    repeat (5) @(negedge clk);
    chk(done == 0 && result == ref_steps(300), "R9 held", result, ref_steps(300));
    run(1000, 999, 5, r); // R8 start on last step
    run(65535, -1, 0, r);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule